// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steps a microprogrammed control unit through its control store. It holds the 9-bit microprogram counter, reads the microinstruction stored at that address and presents it as the current control word. The next address is built from fields inside that word. These are a 9-bit successor address and three branch bits: dispatch on opcode, jump on negative, and jump on zero. The block combines them with two latched ALU flags and the 8-bit opcode byte from the instruction fetch path.

The next address comes from bitwise OR, with no adders and no multiplexers. The flag conditions are ORed into bit 8, so a two-way branch lands in either the lower or the upper half of the store at the same low offset. The opcode byte is ORed into the low eight bits, so a dispatch jumps to the table entry at the opcode value. Because of this, a dispatch normally uses a successor address of 0x000 or 0x100.

The control store is a register array. Reset clears it, and a write port fills it. While a word is being written, the counter and the flags hold.

Top module: `usequencer`

## Requirements
- R1: While reset is low, and at the first clock after reset is released, the counter is 0x000 and the current control word is all zeros. Reset also clears both latched flags.
- R2: On a clock with the write enable high, the word on the write-data port is stored at the write address. On that clock the counter and both latched flags keep their values.
- R3: On a clock with the write enable low, bit 8 of the new counter is successor bit 8, ORed with (zero-jump bit AND latched Z), ORed with (negative-jump bit AND latched N).
- R4: On a clock with the write enable low, bits 7:0 of the new counter are successor bits 7:0. When the dispatch bit is set, they are ORed with the opcode byte.
- R5: The latched N and Z flags take the ALU flag inputs at each clock with the write enable low. A branch therefore tests the flags presented during the previous microinstruction.
- R6: A zero-jump word with successor 0x002 goes to 0x102 when latched Z is 1 and to 0x002 when it is 0. A negative-jump word with successor 0x003 goes to 0x103 when latched N is 1 and to 0x003 when it is 0.
- R7: A dispatch with successor 0x000 goes to the opcode value. A dispatch with successor 0x100 goes to 0x100 plus the opcode value.
- R8: The current control word is the store entry at the current counter value. It is visible in the same cycle, and a write to that entry shows up in the following cycle.
- R9: A dispatch whose successor low byte is 0xFF goes to 0x0FF or 0x1FF, whatever the opcode byte is.
- Word layout (WORD_W = 36): bits 35:27 are the successor address, bit 26 is the dispatch bit, bit 25 is the negative-jump bit, bit 24 is the zero-jump bit, and bits 23:0 are datapath controls that pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write a control-store word; the counter and flags pause |
| wr_addr | input | 9 | Write address |
| wr_word | input | 36 | Write data |
| alu_n | input | 1 | ALU negative flag of the current microinstruction |
| alu_z | input | 1 | ALU zero flag of the current microinstruction |
| opcode | input | 8 | Opcode byte from the completed fetch |
| upc | output | 9 | Current microprogram counter |
| uword | output | 36 | Control word at the current counter |

## Verification
The bench uses the default parameters: a 9-bit counter and a 36-bit word. This gives the full 512-entry store, and both halves are reachable, so a branch can land at 0x1xx and the collapse cases at 0x0FF and 0x1FF can be reached. A directed program walks the taken and untaken paths of both flag branches and dispatches from both bases. A long random run then mixes writes, flags and opcodes. A behavioural model checks the counter and the word on every cycle.

// File: rtl/usequencer.sv
module usequencer #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              alu_n,
  input  logic              alu_z,
  input  logic [ADDR_W-2:0] opcode,
  output logic [ADDR_W-1:0] upc,
  output logic [WORD_W-1:0] uword
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LOW_W  = ADDR_W - 1;
  localparam int SUCC_L = WORD_W - ADDR_W;
  localparam int DISP_B = SUCC_L - 1;
  localparam int NEG_B  = SUCC_L - 2;
  localparam int ZER_B  = SUCC_L - 3;

  logic [WORD_W-1:0] store [DEPTH];
  logic              n_q, z_q;
  logic [ADDR_W-1:0] succ, next_pc;
  logic              disp, jneg, jzer, hi;
  logic [LOW_W-1:0]  lo;

  assign uword = store[upc];
  assign succ  = uword[WORD_W-1 -: ADDR_W];
  assign disp  = uword[DISP_B];
  assign jneg  = uword[NEG_B];
  assign jzer  = uword[ZER_B];

  assign hi      = succ[ADDR_W-1] | (jzer & z_q) | (jneg & n_q);
  assign lo      = succ[LOW_W-1:0] | (disp ? opcode : '0);
  assign next_pc = {hi, lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc <= '0;
      n_q <= 1'b0;
      z_q <= 1'b0;
    end else if (!wr_en) begin
      upc <= next_pc;
      n_q <= alu_n;
      z_q <= alu_z;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (wr_en) begin
      store[wr_addr] <= wr_word;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (upc == '0 && uword == '0));

  p_hold_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (upc == $past(upc)));

  p_low_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !disp) |=> (upc[LOW_W-1:0] == $past(succ[LOW_W-1:0])));

  p_low_superset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && disp) |=> ((upc[LOW_W-1:0] & $past(succ[LOW_W-1:0])) == $past(succ[LOW_W-1:0])));

  p_hi_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && succ[ADDR_W-1]) |=> upc[ADDR_W-1]);

  p_hi_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !succ[ADDR_W-1] && !jzer && !jneg) |=> !upc[ADDR_W-1]);

  p_flag_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (z_q == $past(alu_z) && n_q == $past(alu_n)));

  p_collapse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && disp && succ[LOW_W-1:0] == '1) |=> (upc[LOW_W-1:0] == '1));
endmodule

// File: tb/usequencer_test.sv
`timescale 1ns/1ps
module usequencer_test;
  localparam int AW = 9;
  localparam int WW = 36;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_word = '0;
  logic alu_n = 1'b0, alu_z = 1'b0;
  logic [AW-2:0] opcode = '0;
  logic [AW-1:0] upc;
  logic [WW-1:0] uword;

  usequencer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_word(wr_word), .alu_n(alu_n), .alu_z(alu_z), .opcode(opcode),
    .upc(upc), .uword(uword));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [WW-1:0] m_store [DEPTH];
  int m_pc = 0;
  bit m_n = 0, m_z = 0;

  function automatic logic [WW-1:0] mk(int succ, bit d, bit jn, bit jz, int ctl);
    logic [WW-1:0] w;
    w = {WW{1'b0}};
    w[35:27] = succ[8:0];
    w[26] = d; w[25] = jn; w[24] = jz;
    w[23:0] = ctl[23:0];
    return w;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    logic [WW-1:0] w;
    int nxt;
    w = m_store[m_pc];
    nxt = m_pc;
    if (!wr_en) begin
      nxt = int'(w[35:27]);
      if ((w[24] && m_z) || (w[25] && m_n)) nxt = nxt | 256;
      if (w[26]) nxt = nxt | int'(opcode);
    end
    @(posedge clk);
    if (wr_en) m_store[wr_addr] = wr_word;
    else begin m_pc = nxt; m_n = alu_n; m_z = alu_z; end
    @(negedge clk);
    check(int'(upc) == m_pc, {tag, " upc"}, upc, m_pc);
    check(uword == m_store[m_pc], {tag, " R8 uword"}, uword, m_store[m_pc]);
  endtask

  task automatic put(int a, logic [WW-1:0] w);
    wr_en = 1; wr_addr = a[8:0]; wr_word = w;
    tick("R2 write");
    wr_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_store[i] = '0;
    repeat (3) @(negedge clk);
    check(upc == 0 && uword == 0, "R1 in reset", upc, 0);
    rst_n = 1;
    @(negedge clk);
    m_pc = 0;
    check(upc == 0 && uword == 0, "R1 after release", upc, 0);
    put(0, mk(1, 0, 0, 0, 'hA));
    check(upc == 0, "R2 hold while writing", upc, 0);
    check(uword == mk(1, 0, 0, 0, 'hA), "R8 new word at pc", uword, mk(1, 0, 0, 0, 'hA));
    put(1, mk(2, 0, 0, 1, 'h1));
    put('h102, mk('h100, 1, 0, 0, 'h2));
    put(2, mk(0, 1, 0, 0, 'h3));
    put('h60, mk(3, 0, 1, 0, 'h4));
    put('h103, mk('h0FF, 1, 0, 0, 'h5));
    put('h0FF, mk('h1FF, 1, 0, 0, 'h6));
    check(upc == 0, "R2 pc held over writes", upc, 0);

    alu_z = 1; tick("R5");
    check(upc == 1, "R5 step", upc, 1);
    alu_z = 0; tick("R6");
    check(upc == 'h102, "R6 Z taken R3", upc, 'h102);
    opcode = 'h15; tick("R7");
    check(upc == 'h115, "R7 base 0x100", upc, 'h115);
    tick("R4");
    check(upc == 0, "R4 plain successor", upc, 0);
    alu_z = 0; tick("R5");
    tick("R6");
    check(upc == 2, "R6 Z not taken", upc, 2);
    alu_n = 1; opcode = 'h60; tick("R7");
    check(upc == 'h60, "R7 base 0x000", upc, 'h60);
    alu_n = 0; tick("R6");
    check(upc == 'h103, "R6 N taken", upc, 'h103);
    opcode = 'h15; tick("R9");
    check(upc == 'h0FF, "R9 collapse low", upc, 'h0FF);
    opcode = 'h60; tick("R9");
    check(upc == 'h1FF, "R9 collapse high", upc, 'h1FF);
    tick("R4"); tick("R4");
    check(upc == 1, "R4 back to 1", upc, 1);
    put('h60, mk(3, 0, 1, 0, 'h4));
    alu_z = 1; alu_n = 1; put(5, '0);
    check(upc == 1, "R2 pc held", upc, 1);
    alu_z = 0; alu_n = 0; tick("R5 flags held");
    check(upc == 2, "R5 flags held over write", upc, 2);
    opcode = 'h60; alu_n = 0; tick("R7"); tick("R6");
    check(upc == 3, "R6 N not taken", upc, 3);

    for (int k = 0; k < 3000; k++) begin
      alu_n = 1'($urandom); alu_z = 1'($urandom); opcode = 8'($urandom);
      if ($urandom_range(0, 5) == 0) begin
        wr_en = 1; wr_addr = 9'($urandom);
        wr_word = {9'($urandom), 3'($urandom), 24'($urandom)};
      end
      tick("R3 R4 random");
      wr_en = 0;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule